// File: doc/BRIEF.md
# Transmit Descriptor Ring Walker

This block drains a ring of transmit buffer descriptors kept in system memory. Software points the block at the start of the ring, sets the controller enable, and pulses the activate input. The walker then reads descriptors one after another from its current ring pointer. For every descriptor marked ready it fetches the referenced buffer through a single-word memory port and streams the bytes out one per cycle. It then writes the descriptor's first word back with the ready mark removed and moves on. The walk ends at the first descriptor that is not ready, or when a per-activation descriptor budget is used up.

Each descriptor is two 32-bit words at consecutive word addresses. Word 0 carries a 16-bit flag field in bits 31:16 and a 16-bit buffer length in bits 15:0. Word 1 is the byte address of the buffer. In the flag field, bit 15 is ready, bit 13 is wrap and bit 11 is last. Buffer bytes are little-endian within a memory word: the byte at address a sits in bits 8*(a mod 4)+7 down to 8*(a mod 4) of the word at a with its two low bits cleared. A frame may span several descriptors. Its running length is clamped to a maximum frame size, and an overrun raises a babbling-transmit pulse.

The controller is a six-state machine. IDLE moves to FETCH_HDR on an honoured activation (kick with enable high). FETCH_HDR reads word 0. On the memory acknowledge it returns to IDLE (stop: ready clear) or moves to FETCH_PTR. FETCH_PTR reads word 1 and applies the length clamp. It goes to FETCH_DATA, or straight to WRITE_BACK when the clamped length is zero. FETCH_DATA loads one memory word and enters SEND. SEND emits one byte per cycle. It goes back to FETCH_DATA at a word boundary and leaves for WRITE_BACK after the final byte. WRITE_BACK stores word 0 and advances the pointer. It then returns to FETCH_HDR, or to IDLE once the descriptor budget is reached.

Top module: `tdr_tx_ring_engine`

## Requirements
- R1: After reset, busy, mem_req, tx_valid and all event pulses are low, and ring_base and cur_ptr are zero.
- R2: A kick while enable is low is ignored: no memory request is made, busy stays low and cur_ptr is unchanged.
- R3: A walk starts at cur_ptr and stops at the first descriptor whose ready flag (flag bit 15, word 0 bit 31) is clear. That descriptor is not written back and the pointer stays on it. busy is high during the walk and low after it.
- R4: The buffer's clamped length in bytes appears on tx_data in ascending address order, one byte per tx_valid cycle, with little-endian lane selection, for any buffer alignment.
- R5: If the running frame length plus the buffer length exceeds MAX_FRAME, only the remaining room is sent and evt_babble pulses once. A total exactly equal to MAX_FRAME is not clamped.
- R6: On a descriptor with the last flag (flag bit 11), frame_done pulses once with frame_len equal to the frame's total sent length, and the running length restarts at zero. A partial frame never carries over to the next activation.
- R7: Every consumed descriptor pulses evt_buf once and has word 0 rewritten with bit 31 cleared and all other bits, including the original length, unchanged.
- R8: After a descriptor with the wrap flag (flag bit 13), cur_ptr returns to ring_base; otherwise it advances by 8 bytes.
- R9: At most MAX_DESC descriptors are consumed per activation; the next activation continues from the following descriptor.
- R10: Writing the ring base forces its ALIGN_BITS low bits to zero and loads cur_ptr with it; while enable is low and the block is idle, cur_ptr is reloaded from ring_base.
- R11: A memory request, once raised, stays raised with a stable address, direction and write data until mem_ack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Controller enable level |
| kick | input | 1 | Transmit activate strobe |
| base_we | input | 1 | Ring base write strobe |
| base_wdata | input | AW | Ring base write value |
| ring_base | output | AW | Aligned ring base |
| cur_ptr | output | AW | Current descriptor pointer |
| busy | output | 1 | Activation in progress; reads 0 once processing is done |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | AW | Word-aligned memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory acknowledge, one cycle, ends the request |
| mem_rdata | input | 32 | Memory read data, valid with mem_ack |
| tx_valid | output | 1 | Transmit byte valid |
| tx_data | output | 8 | Transmit byte |
| frame_done | output | 1 | Frame-transmitted event pulse |
| frame_len | output | LEN_W | Total length of the completed frame |
| evt_buf | output | 1 | Buffer-transmitted event pulse |
| evt_babble | output | 1 | Babbling-transmit error pulse |

## Verification
The embedded properties watch, on every cycle, the memory request hold rule, the refusal of kicks while disabled, the alignment of the ring base, the fixed pointer stride, the frame-length bound after clamping, and the per-activation descriptor budget. Only the bench's scenarios can show the byte order and lane choice across every buffer alignment, the exact write-back word, where the pointer ends after wrap, stop and budget exhaustion, and the clamp at and just past the size limit. It does this with a sweep over four alignments and nine lengths plus chained, clamped and budget-limited rings in a small configuration.

// File: rtl/tdr_pkg.sv
package tdr_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH_HDR,
        ST_FETCH_PTR,
        ST_FETCH_DATA,
        ST_SEND,
        ST_WRITE_BACK
    } tdr_state_e;

    localparam int FLAG_READY = 15;
    localparam int FLAG_WRAP  = 13;
    localparam int FLAG_LAST  = 11;
    localparam int DESC_BYTES = 8;
endpackage

// File: rtl/tdr_len_clamp.sv
module tdr_len_clamp #(
    parameter int LEN_W     = 16,
    parameter int MAX_FRAME = 2048
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LEN_W-1:0] acc,
    input  logic [LEN_W-1:0] len_in,
    output logic [LEN_W-1:0] len_out,
    output logic             over
);
    localparam int SW = LEN_W + 1;
    localparam logic [SW-1:0] LIMIT = SW'(MAX_FRAME);

    logic [SW-1:0] sum;
    logic [SW-1:0] room;

    always_comb begin
        sum     = {1'b0, acc} + {1'b0, len_in};
        room    = LIMIT - {1'b0, acc};
        over    = sum > LIMIT;
        len_out = over ? room[LEN_W-1:0] : len_in;
    end

    // R5: the clamped piece never pushes the frame past the limit
    a_r5_fits_limit: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, acc} <= LIMIT) |-> ({1'b0, acc} + {1'b0, len_out} <= LIMIT));
endmodule

// File: rtl/tdr_ring_ptr.sv
module tdr_ring_ptr #(
    parameter int AW         = 32,
    parameter int ALIGN_BITS = 3,
    parameter int STEP       = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          base_we,
    input  logic [AW-1:0] base_wdata,
    input  logic          reload,
    input  logic          advance,
    input  logic          wrap,
    output logic [AW-1:0] base_q,
    output logic [AW-1:0] ptr_q
);
    localparam logic [AW-1:0] MASK = {{(AW-ALIGN_BITS){1'b1}}, {ALIGN_BITS{1'b0}}};
    localparam logic [AW-1:0] STEP_V = AW'(STEP);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
            ptr_q  <= '0;
        end else if (base_we) begin
            base_q <= base_wdata & MASK;
            ptr_q  <= base_wdata & MASK;
        end else if (reload) begin
            ptr_q <= base_q;
        end else if (advance) begin
            ptr_q <= wrap ? base_q : ptr_q + STEP_V;
        end
    end

    // R10: the stored base keeps its low bits clear
    a_r10_base_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        base_q[ALIGN_BITS-1:0] == '0);

    // R8: a plain advance moves exactly one descriptor
    a_r8_stride: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !wrap && !reload && !base_we) |=> (ptr_q == $past(ptr_q) + STEP_V));
endmodule

// File: rtl/tdr_tx_ring_engine.sv
module tdr_tx_ring_engine
    import tdr_pkg::*;
#(
    parameter int AW         = 32,
    parameter int LEN_W      = 16,
    parameter int MAX_FRAME  = 2048,
    parameter int MAX_DESC   = 1024,
    parameter int ALIGN_BITS = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             kick,
    input  logic             base_we,
    input  logic [AW-1:0]    base_wdata,
    output logic [AW-1:0]    ring_base,
    output logic [AW-1:0]    cur_ptr,
    output logic             busy,
    output logic             mem_req,
    output logic             mem_we,
    output logic [AW-1:0]    mem_addr,
    output logic [31:0]      mem_wdata,
    input  logic             mem_ack,
    input  logic [31:0]      mem_rdata,
    output logic             tx_valid,
    output logic [7:0]       tx_data,
    output logic             frame_done,
    output logic [LEN_W-1:0] frame_len,
    output logic             evt_buf,
    output logic             evt_babble
);
    localparam int CNT_W = $clog2(MAX_DESC + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(MAX_DESC - 1);
    localparam logic [AW-1:0] PTR_WORD1 = AW'(4);

    tdr_state_e state_q, state_d;

    logic [15:0]      flags_q;
    logic [LEN_W-1:0] len_q;
    logic [AW-1:0]    baddr_q;
    logic [LEN_W-1:0] rem_q;
    logic [LEN_W-1:0] acc_q;
    logic [31:0]      word_q;
    logic [CNT_W-1:0] cnt_q;

    logic [LEN_W-1:0] len_eff;
    logic             len_over;
    logic             start;
    logic             wb_done;
    logic             reload;

    assign start   = (state_q == ST_IDLE) && kick && en;
    assign wb_done = (state_q == ST_WRITE_BACK) && mem_ack;
    assign reload  = !en && (state_q == ST_IDLE);

    tdr_len_clamp #(
        .LEN_W     (LEN_W),
        .MAX_FRAME (MAX_FRAME)
    ) u_clamp (
        .clk     (clk),
        .rst_n   (rst_n),
        .acc     (acc_q),
        .len_in  (len_q),
        .len_out (len_eff),
        .over    (len_over)
    );

    tdr_ring_ptr #(
        .AW         (AW),
        .ALIGN_BITS (ALIGN_BITS),
        .STEP       (DESC_BYTES)
    ) u_ptr (
        .clk        (clk),
        .rst_n      (rst_n),
        .base_we    (base_we),
        .base_wdata (base_wdata),
        .reload     (reload),
        .advance    (wb_done),
        .wrap       (flags_q[FLAG_WRAP]),
        .base_q     (ring_base),
        .ptr_q      (cur_ptr)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) state_d = ST_FETCH_HDR;
            end
            ST_FETCH_HDR: begin
                if (mem_ack) begin
                    state_d = mem_rdata[16 + FLAG_READY] ? ST_FETCH_PTR : ST_IDLE;
                end
            end
            ST_FETCH_PTR: begin
                if (mem_ack) begin
                    state_d = (len_eff == '0) ? ST_WRITE_BACK : ST_FETCH_DATA;
                end
            end
            ST_FETCH_DATA: begin
                if (mem_ack) state_d = ST_SEND;
            end
            ST_SEND: begin
                if (rem_q == LEN_W'(1))          state_d = ST_WRITE_BACK;
                else if (baddr_q[1:0] == 2'b11)  state_d = ST_FETCH_DATA;
                else                             state_d = ST_SEND;
            end
            ST_WRITE_BACK: begin
                if (mem_ack) state_d = (cnt_q == CNT_LAST) ? ST_IDLE : ST_FETCH_HDR;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags_q <= '0;
            len_q   <= '0;
            baddr_q <= '0;
            rem_q   <= '0;
            acc_q   <= '0;
            word_q  <= '0;
            cnt_q   <= '0;
        end else begin
            if (start) begin
                acc_q <= '0;
                cnt_q <= '0;
            end
            if (state_q == ST_FETCH_HDR && mem_ack) begin
                flags_q <= mem_rdata[31:16];
                len_q   <= mem_rdata[LEN_W-1:0];
            end
            if (state_q == ST_FETCH_PTR && mem_ack) begin
                baddr_q <= mem_rdata[AW-1:0];
                rem_q   <= len_eff;
                acc_q   <= acc_q + len_eff;
            end
            if (state_q == ST_FETCH_DATA && mem_ack) begin
                word_q <= mem_rdata;
            end
            if (state_q == ST_SEND) begin
                baddr_q <= baddr_q + AW'(1);
                rem_q   <= rem_q - LEN_W'(1);
            end
            if (wb_done) begin
                cnt_q <= cnt_q + CNT_W'(1);
                if (flags_q[FLAG_LAST]) acc_q <= '0;
            end
        end
    end

    // outputs
    always_comb begin
        mem_req    = 1'b0;
        mem_we     = 1'b0;
        mem_addr   = cur_ptr;
        mem_wdata  = '0;
        tx_valid   = 1'b0;
        tx_data    = word_q[{baddr_q[1:0], 3'b000} +: 8];
        frame_done = 1'b0;
        frame_len  = acc_q;
        evt_buf    = 1'b0;
        evt_babble = 1'b0;
        busy       = (state_q != ST_IDLE);
        unique case (state_q)
            ST_IDLE: ;
            ST_FETCH_HDR: begin
                mem_req = 1'b1;
            end
            ST_FETCH_PTR: begin
                mem_req    = 1'b1;
                mem_addr   = cur_ptr + PTR_WORD1;
                evt_babble = mem_ack && len_over;
            end
            ST_FETCH_DATA: begin
                mem_req  = 1'b1;
                mem_addr = {baddr_q[AW-1:2], 2'b00};
            end
            ST_SEND: begin
                tx_valid = 1'b1;
            end
            ST_WRITE_BACK: begin
                mem_req    = 1'b1;
                mem_we     = 1'b1;
                mem_wdata  = {flags_q & ~(16'h1 << FLAG_READY), 16'(len_q)};
                evt_buf    = mem_ack;
                frame_done = mem_ack && flags_q[FLAG_LAST];
            end
            default: ;
        endcase
    end

    // R11: a raised request waits for its acknowledge unchanged
    a_r11_hold_req: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

    // R2: with enable low an idle walker stays idle
    a_r2_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !en) |=> !busy);

    // R6: a completed frame never reports more than the limit
    a_r6_frame_bound: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> (frame_len <= LEN_W'(MAX_FRAME)));

    // R9: the budget counter is below the cap whenever a descriptor is consumed
    a_r9_budget: assert property (@(posedge clk) disable iff (!rst_n)
        evt_buf |-> (cnt_q < CNT_W'(MAX_DESC)));

    // R4: bytes are only streamed during an activation with no memory traffic
    a_r4_send_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> (busy && !mem_req));
endmodule

// File: tb/test_tdr_tx_ring_engine.sv
`timescale 1ns/100ps
module test_tdr_tx_ring_engine;
    localparam int AW = 32;
    localparam int LW = 16;
    localparam int MAXF = 24;
    localparam int MAXD = 4;
    localparam int DBASE = 32'h40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0, kick = 1'b0, base_we = 1'b0;
    logic [AW-1:0] base_wdata = '0;
    logic [AW-1:0] ring_base, cur_ptr, mem_addr;
    logic busy, mem_req, mem_we, tx_valid, frame_done, evt_buf, evt_babble;
    logic [31:0] mem_wdata, mem_rdata;
    logic mem_ack;
    logic [7:0] tx_data;
    logic [LW-1:0] frame_len;

    always #2.5 clk = ~clk;

    tdr_tx_ring_engine #(
        .AW(AW), .LEN_W(LW), .MAX_FRAME(MAXF), .MAX_DESC(MAXD), .ALIGN_BITS(3)
    ) i_tdr_tx_ring_engine (
        .clk(clk), .rst_n(rst_n), .en(en), .kick(kick),
        .base_we(base_we), .base_wdata(base_wdata),
        .ring_base(ring_base), .cur_ptr(cur_ptr), .busy(busy),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .tx_valid(tx_valid), .tx_data(tx_data),
        .frame_done(frame_done), .frame_len(frame_len),
        .evt_buf(evt_buf), .evt_babble(evt_babble)
    );

    // memory model: 2 KB, acknowledge one cycle after the request
    logic [31:0] mem [0:511];
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_ack   <= 1'b0;
            mem_rdata <= '0;
        end else begin
            mem_ack <= 1'b0;
            if (mem_req && !mem_ack) begin
                mem_ack <= 1'b1;
                if (mem_we) mem[mem_addr[10:2]] <= mem_wdata;
                else        mem_rdata <= mem[mem_addr[10:2]];
            end
        end
    end

    // monitor
    logic [7:0] txq [0:4095];
    int txn = 0, nbuf = 0, nframe = 0, nbab = 0, reqs = 0;
    int flen = -1;
    always @(negedge clk) begin
        if (tx_valid) begin txq[txn] = tx_data; txn++; end
        if (evt_buf) nbuf++;
        if (frame_done) begin nframe++; flen = int'(frame_len); end
        if (evt_babble) nbab++;
        if (mem_req) reqs++;
    end

    int checks = 0, failures = 0;

    function automatic logic [7:0] eb(int a);
        return 8'((a * 7 + 5) & 255);
    endfunction

    task automatic check(bit ok, string req, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk); #1;
    endtask

    task automatic put_desc(int idx, logic [15:0] fl, logic [15:0] ln, logic [31:0] ad);
        mem[(DBASE >> 2) + 2 * idx]     = {fl, ln};
        mem[(DBASE >> 2) + 2 * idx + 1] = ad;
    endtask

    task automatic clear_descs();
        for (int i = 0; i < 16; i++) put_desc(i, 16'h0, 16'h0, 32'h0);
    endtask

    task automatic zero_mon();
        txn = 0; nbuf = 0; nframe = 0; nbab = 0; flen = -1; reqs = 0;
    endtask

    task automatic kick_and_wait();
        kick = 1'b1;
        step();
        kick = 1'b0;
        for (int n = 0; n < 5000 && busy; n++) step();
        step();
    endtask

    function automatic int byte_errs(int first, int from, int cnt);
        int e = 0;
        for (int k = 0; k < cnt; k++) if (txq[first + k] !== eb(from + k)) e++;
        return e;
    endfunction

    initial begin
        for (int w = 0; w < 512; w++)
            mem[w] = {eb(4*w+3), eb(4*w+2), eb(4*w+1), eb(4*w)};
        clear_descs();
        step(); step();
        rst_n = 1'b1;
        step();

        // R1: reset state
        check(!busy && !mem_req && !tx_valid, "R1", "idle outputs", {busy, mem_req, tx_valid}, 0);
        check(cur_ptr == 0 && ring_base == 0, "R1", "pointers", cur_ptr, 0);
        check(!frame_done && !evt_buf && !evt_babble, "R1", "events", {frame_done, evt_buf, evt_babble}, 0);

        // R10: base write aligns and loads the pointer
        base_wdata = 32'h10F; base_we = 1'b1; step(); base_we = 1'b0; step();
        check(ring_base == 32'h108, "R10", "aligned base", ring_base, 32'h108);
        check(cur_ptr == 32'h108, "R10", "pointer load", cur_ptr, 32'h108);
        base_wdata = DBASE; base_we = 1'b1; step(); base_we = 1'b0; step();

        // R2: kick while disabled is ignored
        put_desc(0, 16'hA800, 16'd3, 32'h200);
        zero_mon();
        kick = 1'b1; step(); kick = 1'b0; step(); step(); step();
        check(!busy && reqs == 0 && nbuf == 0, "R2", "no activity", reqs, 0);
        check(cur_ptr == DBASE, "R2", "pointer kept", cur_ptr, DBASE);
        en = 1'b1; step();

        // Sweep: alignment x length, single-buffer wrapped frames (R4 R6 R7 R8 R3)
        for (int off = 0; off < 4; off++) begin
            for (int ln = 1; ln <= 9; ln++) begin
                int ba;
                ba = 32'h200 + off + 32 * ln;
                clear_descs();
                put_desc(0, 16'hA804, 16'(ln), 32'(ba));
                zero_mon();
                kick_and_wait();
                check(txn == ln && byte_errs(0, ba, ln) == 0, "R4", "stream bytes", txn, ln);
                check(nframe == 1 && flen == ln, "R6", "frame length", flen, ln);
                check(nbuf == 1 && mem[DBASE >> 2] == {16'h2804, 16'(ln)}, "R7", "write-back", mem[DBASE >> 2], {16'h2804, 16'(ln)});
                check(cur_ptr == DBASE && !busy, "R8", "wrap to base and stop (R3)", cur_ptr, DBASE);
            end
        end

        // Two-descriptor frame, plain advance (R6 R8)
        clear_descs();
        put_desc(0, 16'h8000, 16'd3, 32'h300);
        put_desc(1, 16'h8800, 16'd4, 32'h341);
        zero_mon();
        kick_and_wait();
        check(txn == 7 && byte_errs(0, 32'h300, 3) == 0 && byte_errs(3, 32'h341, 4) == 0, "R4", "chained bytes", txn, 7);
        check(nframe == 1 && flen == 7 && nbuf == 2, "R6", "chained frame", flen, 7);
        check(cur_ptr == DBASE + 16, "R8", "advance by 8", cur_ptr, DBASE + 16);
        // R3: pointer sits on a non-ready descriptor, nothing consumed
        zero_mon();
        kick_and_wait();
        check(nbuf == 0 && txn == 0 && cur_ptr == DBASE + 16, "R3", "stop at not-ready", cur_ptr, DBASE + 16);
        check(mem[(DBASE >> 2) + 4] == 32'h0, "R3", "no write-back", mem[(DBASE >> 2) + 4], 0);

        // R10: disable reloads pointer from base
        en = 1'b0; step(); step();
        check(cur_ptr == DBASE, "R10", "reload on disable", cur_ptr, DBASE);
        en = 1'b1; step();

        // R5: exact limit, no clamp
        clear_descs();
        put_desc(0, 16'hA800, 16'(MAXF), 32'h400);
        zero_mon();
        kick_and_wait();
        check(nbab == 0 && flen == MAXF && txn == MAXF, "R5", "exact limit unclamped", flen, MAXF);

        // R5: overrun clamps the second buffer
        clear_descs();
        put_desc(0, 16'h8000, 16'd20, 32'h400);
        put_desc(1, 16'hA800, 16'd10, 32'h500);
        zero_mon();
        kick_and_wait();
        check(nbab == 1, "R5", "babble pulse", nbab, 1);
        check(txn == MAXF && flen == MAXF && byte_errs(20, 32'h500, 4) == 0, "R5", "clamped length", txn, MAXF);
        check(mem[(DBASE >> 2) + 2] == {16'h2800, 16'd10}, "R7", "original length kept", mem[(DBASE >> 2) + 2], {16'h2800, 16'd10});

        // R9: descriptor budget per activation
        clear_descs();
        for (int i = 0; i < 5; i++) put_desc(i, 16'h8000, 16'd1, 32'(32'h600 + i));
        zero_mon();
        kick_and_wait();
        check(nbuf == MAXD && cur_ptr == DBASE + 8 * MAXD, "R9", "budget stop", nbuf, MAXD);
        check(mem[(DBASE >> 2) + 8][31] == 1'b1 && nframe == 0, "R9", "fifth untouched", mem[(DBASE >> 2) + 8], 32'h80000001);
        kick_and_wait();
        check(nbuf == MAXD + 1 && cur_ptr == DBASE + 8 * (MAXD + 1), "R9", "resume", nbuf, MAXD + 1);
        check(nframe == 0 && txn == 5, "R6", "partial frame dropped", nframe, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule